// File: doc/BRIEF.md
# Two-Axis Quarter-Arc Step Interpolator

This block produces unit step pulses for two machine axes so that a tool traces a circular arc in the first quadrant. It travels clockwise: the horizontal coordinate only grows and the vertical coordinate only shrinks. The block keeps an integer error term, the squared distance of the current point from the centre minus the squared radius. The error is updated with additions only, and its sign alone picks which single axis moves on each step.

A host places the start and end coordinates on the inputs and pulses `start` for one clock. The start point must lie on the arc, so the error begins at zero. While the arc runs, `busy` stays high. The live position and the error are visible at all times. When both coordinates reach the end point, `busy` drops and the pulses stop. Feed rate, other quadrants and the opposite direction are left to surrounding logic.

Top module: `arc_interp`

## Requirements
- R1: After reset, `busy`, `step_x` and `step_y` are 0 and `dev` is 0.
- R2: A `start` pulse while idle loads `pos_x`/`pos_y` from the start inputs, clears `dev` to 0, and raises `busy` on the next clock edge.
- R3: When `dev` >= 0 (signed), a step raises `step_y` (a move in the -Y direction). `pos_y` goes down by 1, and `dev` gains 1 - 2*y, where y is the value before the step.
- R4: When `dev` < 0, a step raises `step_x` (a move in the +X direction). `pos_x` goes up by 1, and `dev` gains 2*x + 1, where x is the value before the step.
- R5: `step_x` and `step_y` are never high in the same cycle.
- R6: Each step pulse lasts one clock and is followed by at least one clock with neither pulse, so steps come at most every second clock.
- R7: `busy` falls once `pos_x`/`pos_y` equal the end point, and no pulse follows. A radius-5 arc from (0,5) to (5,0) takes exactly 10 steps.
- R8: A `start` pulse while `busy` is high has no effect on the trajectory, the end point or the step count.
- R9: An axis that already sits at its end coordinate is not stepped. Its partner steps instead, whatever the sign of `dev`.
- R10: If the start point equals the end point, `busy` is high for exactly one clock and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin an arc |
| x_start | input | COORD_W | Start X coordinate |
| y_start | input | COORD_W | Start Y coordinate |
| x_end | input | COORD_W | End X coordinate |
| y_end | input | COORD_W | End Y coordinate |
| step_x | output | 1 | +X step pulse |
| step_y | output | 1 | -Y step pulse |
| busy | output | 1 | Arc in progress |
| pos_x | output | COORD_W | Current X coordinate |
| pos_y | output | COORD_W | Current Y coordinate |
| dev | output | COORD_W+3 | Signed error term x²+y²−r² |

## Verification
The hardest case to reach is a `start` pulse that lands in the middle of a running arc. On a correct design it leaves no trace, so the only evidence is the full trajectory that follows. The bench raises `start` after the third step, with different coordinates on the inputs. It then requires the step count, every intermediate error value and the final point to match an undisturbed run. The guard that keeps an axis still at its end coordinate never acts on a consistent arc. It is reached by giving an end point that shares its Y value with the start point, which forces X steps even though the error is non-negative.

// File: rtl/arc_pkg.sv
package arc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_REST = 2'd2
    } arc_phase_e;
endpackage

// File: rtl/arc_axis_sel.sv
module arc_axis_sel #(
    parameter int COORD_W = 16,
    parameter int DEV_W   = COORD_W + 3
) (
    input  logic signed [DEV_W-1:0]   err,
    input  logic        [COORD_W-1:0] cur_x,
    input  logic        [COORD_W-1:0] cur_y,
    input  logic        [COORD_W-1:0] tgt_x,
    input  logic        [COORD_W-1:0] tgt_y,
    output logic                      go_x,
    output logic                      go_y,
    output logic                      arrived
);
    logic x_done;
    logic y_done;

    always_comb begin
        x_done  = (cur_x == tgt_x);
        y_done  = (cur_y == tgt_y);
        arrived = x_done && y_done;
        go_x    = 1'b0;
        go_y    = 1'b0;
        if (!arrived) begin
            if (x_done) begin
                go_y = 1'b1;
            end else if (y_done) begin
                go_x = 1'b1;
            end else if (err < 0) begin
                go_x = 1'b1;
            end else begin
                go_y = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arc_dev_next.sv
module arc_dev_next #(
    parameter int COORD_W = 16,
    parameter int DEV_W   = COORD_W + 3
) (
    input  logic signed [DEV_W-1:0]   err,
    input  logic        [COORD_W-1:0] cur_x,
    input  logic        [COORD_W-1:0] cur_y,
    input  logic                      go_x,
    input  logic                      go_y,
    output logic signed [DEV_W-1:0]   err_nxt
);
    localparam int PAD = DEV_W - COORD_W - 1;

    logic signed [DEV_W-1:0] inc_x;
    logic signed [DEV_W-1:0] dbl_y;

    always_comb begin
        inc_x = $signed({{PAD{1'b0}}, cur_x, 1'b1});
        dbl_y = $signed({{PAD{1'b0}}, cur_y, 1'b0});
        if (go_x) begin
            err_nxt = err + inc_x;
        end else if (go_y) begin
            err_nxt = err - dbl_y + DEV_W'(1);
        end else begin
            err_nxt = err;
        end
    end
endmodule

// File: rtl/arc_interp.sv
module arc_interp
    import arc_pkg::*;
#(
    parameter int COORD_W = 16,
    localparam int DEV_W  = COORD_W + 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic        [COORD_W-1:0] x_start,
    input  logic        [COORD_W-1:0] y_start,
    input  logic        [COORD_W-1:0] x_end,
    input  logic        [COORD_W-1:0] y_end,
    output logic                      step_x,
    output logic                      step_y,
    output logic                      busy,
    output logic        [COORD_W-1:0] pos_x,
    output logic        [COORD_W-1:0] pos_y,
    output logic signed [DEV_W-1:0]   dev
);
    typedef struct packed {
        arc_phase_e                ph;
        logic [COORD_W-1:0]        x;
        logic [COORD_W-1:0]        y;
        logic [COORD_W-1:0]        xe;
        logic [COORD_W-1:0]        ye;
        logic signed [DEV_W-1:0]   f;
        logic                      px;
        logic                      py;
    } arc_state_t;

    arc_state_t s_d;
    arc_state_t s_q;

    logic                    mv_x;
    logic                    mv_y;
    logic                    at_end;
    logic signed [DEV_W-1:0] f_step;

    arc_axis_sel #(.COORD_W(COORD_W), .DEV_W(DEV_W)) u_sel (
        .err     (s_q.f),
        .cur_x   (s_q.x),
        .cur_y   (s_q.y),
        .tgt_x   (s_q.xe),
        .tgt_y   (s_q.ye),
        .go_x    (mv_x),
        .go_y    (mv_y),
        .arrived (at_end)
    );

    arc_dev_next #(.COORD_W(COORD_W), .DEV_W(DEV_W)) u_dev (
        .err     (s_q.f),
        .cur_x   (s_q.x),
        .cur_y   (s_q.y),
        .go_x    (mv_x),
        .go_y    (mv_y),
        .err_nxt (f_step)
    );

    always_comb begin
        s_d    = s_q;
        s_d.px = 1'b0;
        s_d.py = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph = PH_STEP;
                    s_d.x  = x_start;
                    s_d.y  = y_start;
                    s_d.xe = x_end;
                    s_d.ye = y_end;
                    s_d.f  = '0;
                end
            end
            PH_STEP: begin
                if (at_end) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.px = mv_x;
                    s_d.py = mv_y;
                    s_d.x  = mv_x ? s_q.x + COORD_W'(1) : s_q.x;
                    s_d.y  = mv_y ? s_q.y - COORD_W'(1) : s_q.y;
                    s_d.f  = f_step;
                    s_d.ph = PH_REST;
                end
            end
            PH_REST: begin
                s_d.ph = PH_STEP;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{ph: PH_IDLE, x: '0, y: '0, xe: '0, ye: '0,
                     f: '0, px: 1'b0, py: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign step_x = s_q.px;
    assign step_y = s_q.py;
    assign busy   = (s_q.ph != PH_IDLE);
    assign pos_x  = s_q.x;
    assign pos_y  = s_q.y;
    assign dev    = s_q.f;

    // R5: never both axes in one cycle
    a_r5_single_axis: assert property (@(posedge clk) disable iff (rst)
        !(step_x && step_y));

    // R6: a pulse is always followed by a quiet clock
    a_r6_pulse_gap: assert property (@(posedge clk) disable iff (rst)
        (step_x || step_y) |=> !(step_x || step_y));

    // R4: an X step advances x by one from a negative error or a finished y
    a_r4_x_step: assert property (@(posedge clk) disable iff (rst)
        $rose(step_x) |-> (pos_x == $past(pos_x) + COORD_W'(1))
                          && ($past(dev) < 0 || $past(pos_y) == $past(s_q.ye)));

    // R3: a Y step lowers y by one from a non-negative error or a finished x
    a_r3_y_step: assert property (@(posedge clk) disable iff (rst)
        $rose(step_y) |-> (pos_y == $past(pos_y) - COORD_W'(1))
                          && ($past(dev) >= 0 || $past(pos_x) == $past(s_q.xe)));

    // R7: no pulses once idle
    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(step_x || step_y));

    // R8: a start while running leaves the target unchanged
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(s_q.xe) && $stable(s_q.ye));
endmodule

// File: tb/arc_interp_test.sv
module arc_interp_test;
    localparam int CW = 16;
    localparam int DW = CW + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] x_start = '0;
    logic [CW-1:0] y_start = '0;
    logic [CW-1:0] x_end = '0;
    logic [CW-1:0] y_end = '0;
    logic          step_x;
    logic          step_y;
    logic          busy;
    logic [CW-1:0] pos_x;
    logic [CW-1:0] pos_y;
    logic signed [DW-1:0] dev;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    arc_interp #(.COORD_W(CW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .x_start(x_start), .y_start(y_start),
        .x_end(x_end), .y_end(y_end),
        .step_x(step_x), .step_y(step_y), .busy(busy),
        .pos_x(pos_x), .pos_y(pos_y), .dev(dev)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one arc and follows it against a model built from R3/R4/R9.
    task automatic run_arc(input int x0, input int y0, input int xe, input int ye,
                           input int exp_steps, input bit poke);
        int mx = x0;
        int my = y0;
        int mf = 0;
        int steps = 0;
        int cyc = 0;
        bit prev = 1'b0;
        bit want_x;
        @(negedge clk);
        x_start = CW'(x0); y_start = CW'(y0);
        x_end = CW'(xe);   y_end = CW'(ye);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy", int'(busy), 1);
        check(int'(pos_x) == x0 && int'(pos_y) == y0, "R2 load", int'(pos_x), x0);
        check(int'(dev) == 0, "R2 dev", int'(dev), 0);
        while (busy) begin
            if (step_x && step_y) check(1'b0, "R5 both", 2, 1);
            if (step_x || step_y) begin
                if (prev) check(1'b0, "R6 gap", 1, 0);
                if (mx == xe)      want_x = 1'b0;
                else if (my == ye) want_x = 1'b1;
                else               want_x = (mf < 0);
                if (want_x) begin
                    check(step_x == 1'b1, "R4 axis", int'(step_x), 1);
                    mf += 2 * mx + 1; mx++;
                end else begin
                    check(step_y == 1'b1, "R3 axis", int'(step_y), 1);
                    mf += 1 - 2 * my; my--;
                end
                check(int'(pos_x) == mx && int'(pos_y) == my, "R3/R4 pos",
                      int'(pos_x) * 1000 + int'(pos_y), mx * 1000 + my);
                check(int'(dev) == mf, "R3/R4 dev", int'(dev), mf);
                steps++;
                if (poke && steps == 3) begin
                    x_start = CW'(1); y_start = CW'(1);
                    x_end = CW'(9);   y_end = CW'(9);
                    start = 1'b1;
                end
            end else begin
                start = 1'b0;
            end
            prev = step_x || step_y;
            cyc++;
            if (cyc > 5000) begin
                check(1'b0, "R7 watchdog", cyc, 0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(steps == exp_steps, poke ? "R8 steps" : "R7 steps", steps, exp_steps);
        check(int'(pos_x) == xe && int'(pos_y) == ye, "R7 end",
              int'(pos_x) * 1000 + int'(pos_y), xe * 1000 + ye);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!step_x && !step_y && !busy, "R7 quiet", int'(step_x | step_y), 0);
        end
    endtask

    task automatic test_reset();
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(!step_x && !step_y, "R1 pulses", int'(step_x | step_y), 0);
        check(int'(dev) == 0, "R1 dev", int'(dev), 0);
    endtask

    task automatic test_degenerate();
        @(negedge clk);
        x_start = CW'(3); y_start = CW'(4); x_end = CW'(3); y_end = CW'(4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && !step_x && !step_y, "R10 first", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0 && !step_x && !step_y, "R10 done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_arc(0, 5, 5, 0, 10, 1'b0);    // R7 radius 5 full quarter
        run_arc(0, 10, 6, 8, 8, 1'b0);    // partial arc
        run_arc(3, 4, 4, 3, 2, 1'b0);     // short arc
        run_arc(0, 25, 24, 7, 42, 1'b0);  // longer arc
        run_arc(0, 5, 5, 0, 10, 1'b1);    // R8 start during run
        run_arc(0, 5, 2, 5, 2, 1'b0);     // R9 guard forces X steps
        test_degenerate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule